// File: doc/BRIEF.md
# SD Card Power-Up Sequencer

This block takes an SD card from power-on to the transfer state in native SD bus mode. A separate command engine handles the serial framing, CRC and data-line work. This block drives that engine through a narrow request interface. It supplies the command index, the 32-bit argument, the expected response kind, an application-command flag (the engine sends the CMD55 prefix itself) and a data-block flag. It then reads back the response words, followed by a completion strobe that carries error or no-response flags.

The sequence runs in a fixed order: CMD0, CMD8, the ACMD41 query, the ACMD41 poll, CMD2, CMD3, CMD9, CMD7, ACMD51 and, when the card allows it, ACMD6. At several points the sequencer makes a decision from the data it reads back. These points are the interface-condition echo, the OCR voltage window, the OCR ready and capacity bits, the CSD layout field and the SCR bus-width field. When the sequence ends, the block holds either a success flag or a failure flag with a code that names the failing step. It also holds the card's OCR, relative address, block-addressing flag, sector count and 4-bit capability. The block also drives the PHY bus-width control.

Top module: `sdinit_seq`

## Requirements
- R1: After reset, busy, done, fail, fail_code, cmd_req, phy_wide and every card result read 0. A start pulse while idle clears all results, raises busy and requests CMD0 with argument 0, response kind NONE (0) and no app flag.
- R2: CMD8 is requested with argument 0x000001A5 and response kind R7 (6). If the engine reports an error, or returns a word whose low byte is not 0xA5, the sequence stops with fail_code 2. If the engine reports no response, the sequence continues with the high-capacity flag cleared.
- R3: The first ACMD41 (index 41, app flag 1, kind R3 = 4) carries argument 0. If the returned word ANDed with 0x00FF8000 is 0, the sequence stops with fail_code 4. If the query itself errors, fail_code is 3.
- R4: ACMD41 is then repeated with argument (HCS<<30) | (query OCR & 0x00FF8000). HCS is 1 only when CMD8 returned a valid echo. The repetition ends on the first word whose bit 31 is 1. That word becomes ocr, and its bit 30 becomes ccs. An error during this phase gives fail_code 5.
- R5: At most MAX_OP_POLLS repeat requests are issued. If none of them returns bit 31 set, the sequence stops with fail_code 6 after exactly MAX_OP_POLLS repeats.
- R6: CMD2 (kind R2 = 3) is followed by CMD3 (kind R6 = 5), and rca is taken from bits [31:16] of the CMD3 word. An error or no-response on CMD3 is retried exactly once. A second failure gives fail_code 8, and an address of 0 gives fail_code 9.
- R7: CMD9 (kind R2) and CMD7 (kind R1B = 2) both carry the argument rca<<16. An error on either gives fail_code 10 or 12 respectively.
- R8: The CSD is taken from the four CMD9 words, most significant word first. When bits [127:126] equal 1, the sector count is (bits[69:48]+1)*1024. When they equal 0 and bits [83:80] are at least 9, the count is (bits[73:62]+1) << (bits[49:47] + bits[83:80] - 7). Any other value gives fail_code 11.
- R9: ACMD51 (app 1, data flag 1, kind R1 = 1) returns two little-endian 32-bit words. Byte lane k of word j is SCR register byte 4j+k, where byte 0 is the most significant. The 4-bit capability is SCR bit 50. When this bit is set, wide_ok rises and ACMD6 is requested with argument 2 (app 1, kind R1); phy_wide rises once ACMD6 succeeds. When the bit is clear, the bus stays 1-bit and the sequence completes.
- R10: Any other error or no-response stops the sequence with a step code: 1 CMD0, 7 CMD2, 13 ACMD51, 14 ACMD6. fail_code is never 0 while fail is 1.
- R11: done and fail are never high together. Every result holds its value until the next accepted start, and a start pulse while busy has no effect.
- R12: cmd_req is a one-cycle pulse that rises one cycle after an accepted start or after the cmd_done of the previous step. done or fail rises one cycle after the cmd_done of the final step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only while idle) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully |
| fail | output | 1 | Sequence stopped on an error |
| fail_code | output | 4 | Failing step code |
| cmd_req | output | 1 | One-cycle request to the command engine |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rtype | output | 3 | Expected response kind |
| cmd_app | output | 1 | Engine must prefix CMD55 |
| cmd_data | output | 1 | Command returns a data block |
| rsp_valid | input | 1 | Response or data word strobe |
| rsp_word | input | 32 | Response or data word |
| cmd_done | input | 1 | Command finished (after its words) |
| cmd_err | input | 1 | Command failed (CRC, status or data error) |
| cmd_tmo | input | 1 | Card gave no response |
| phy_wide | output | 1 | PHY bus width: 1 = 4-bit |
| ocr | output | 32 | Final OCR |
| rca | output | 16 | Relative card address |
| ccs | output | 1 | Block addressing (capacity status) |
| sect_cnt | output | SECT_W | Card sector count |
| wide_ok | output | 1 | Card supports a 4-bit bus |

## Verification
Each request is due one cycle after start or after the previous cmd_done. The verdict and all results are due one cycle after the final cmd_done. The bench's engine model drops cmd_done on a falling edge, and on that same falling edge it checks that either a new request or a verdict is present. Results are read only after that point. The bench sweeps the success path over every mix of echo/no-echo, capacity bit, bus width, CSD layout and ready delay, up to the poll limit. It also forces each failing step in turn, and it computes the expected command count, arguments and sector count arithmetically.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [2:0] {
    RSP_NONE = 3'd0,
    RSP_R1   = 3'd1,
    RSP_R1B  = 3'd2,
    RSP_R2   = 3'd3,
    RSP_R3   = 3'd4,
    RSP_R6   = 3'd5,
    RSP_R7   = 3'd6
  } rsp_kind_e;

  typedef enum logic [3:0] {
    ST_GO_IDLE, ST_IF_COND, ST_OP_QUERY, ST_OP_POLL, ST_GET_CID,
    ST_GET_RCA, ST_GET_CSD, ST_SELECT, ST_GET_SCR, ST_BUS_WIDTH
  } step_e;

  typedef enum logic [3:0] {
    FC_NONE     = 4'd0,
    FC_GO_IDLE  = 4'd1,
    FC_IF_COND  = 4'd2,
    FC_OP_QUERY = 4'd3,
    FC_NO_VOLT  = 4'd4,
    FC_OP_POLL  = 4'd5,
    FC_OP_TMO   = 4'd6,
    FC_CID      = 4'd7,
    FC_RCA_ERR  = 4'd8,
    FC_RCA_ZERO = 4'd9,
    FC_CSD      = 4'd10,
    FC_CSD_FMT  = 4'd11,
    FC_SELECT   = 4'd12,
    FC_SCR      = 4'd13,
    FC_BUSW     = 4'd14
  } fail_e;

  localparam logic [31:0] IF_COND_ARG = 32'h0000_01A5;
  localparam logic [7:0]  ECHO_PAT    = 8'hA5;
  localparam logic [31:0] VOLT_WINDOW = 32'h00FF_8000;
  localparam logic [31:0] WIDTH4_ARG  = 32'h0000_0002;
  localparam int          SCR_W4_BIT  = 50;

endpackage

// File: rtl/sdinit_rsp_buf.sv
module sdinit_rsp_buf #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    vld,
  input  logic [WORD_W-1:0]       word,
  output logic [WORD_W-1:0]       last_word,
  output logic [WORDS*WORD_W-1:0] long_word,
  output logic [2*WORD_W-1:0]     scr
);
  localparam int TOT_W = WORDS * WORD_W;
  localparam int BYTES = WORD_W / 8;

  logic [TOT_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg <= '0;
    end else if (vld) begin
      shreg <= {shreg[TOT_W-WORD_W-1:0], word};
    end
  end

  assign last_word = shreg[WORD_W-1:0];
  assign long_word = shreg;

  // Data words arrive little-endian; register byte 0 is the most significant.
  for (genvar w = 0; w < 2; w++) begin : g_word
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign scr[(2*BYTES-1-(w*BYTES+b))*8 +: 8] = shreg[(1-w)*WORD_W + b*8 +: 8];
    end
  end

endmodule

// File: rtl/sdinit_csd_decode.sv
module sdinit_csd_decode #(
  parameter int SECT_W = 32
) (
  input  logic [127:0]      csd,
  output logic              ok,
  output logic [SECT_W-1:0] sectors
);
  logic [1:0]  layout;
  logic [21:0] size_hc;
  logic [11:0] size_sc;
  logic [2:0]  size_mult;
  logic [3:0]  blk_len;
  logic [4:0]  shamt;
  logic        csd_unused;

  assign layout    = csd[127:126];
  assign size_hc   = csd[69:48];
  assign size_sc   = csd[73:62];
  assign size_mult = csd[49:47];
  assign blk_len   = csd[83:80];
  assign shamt     = {2'b00, size_mult} + {1'b0, blk_len} - 5'd7;
  assign csd_unused = ^{csd[125:84], csd[79:74], csd[46:0]};

  always_comb begin
    ok      = 1'b0;
    sectors = '0;
    case (layout)
      2'd1: begin
        ok      = 1'b1;
        sectors = (SECT_W'(size_hc) + SECT_W'(1)) << 10;
      end
      2'd0: begin
        if (blk_len >= 4'd9) begin
          ok      = 1'b1;
          sectors = (SECT_W'(size_sc) + SECT_W'(1)) << shamt;
        end
      end
      default: ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int MAX_OP_POLLS = 1000,
  parameter int SECT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [3:0]        fail_code,
  output logic              cmd_req,
  output logic [5:0]        cmd_idx,
  output logic [31:0]       cmd_arg,
  output logic [2:0]        cmd_rtype,
  output logic              cmd_app,
  output logic              cmd_data,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_word,
  input  logic              cmd_done,
  input  logic              cmd_err,
  input  logic              cmd_tmo,
  output logic              phy_wide,
  output logic [31:0]       ocr,
  output logic [15:0]       rca,
  output logic              ccs,
  output logic [SECT_W-1:0] sect_cnt,
  output logic              wide_ok
);
  localparam int PC_W = $clog2(MAX_OP_POLLS + 1);
  localparam logic [PC_W-1:0] POLL_LAST = PC_W'(MAX_OP_POLLS - 1);

  step_e             step;
  logic [PC_W-1:0]   poll_cnt;
  logic              hcs;
  logic              rca_retry;
  logic [31:0]       vmask;
  logic [31:0]       last_w;
  logic [127:0]      long_w;
  logic [63:0]       scr_reg;
  logic              csd_ok;
  logic [SECT_W-1:0] csd_sect;
  logic              bad;
  logic              scr_unused;

  sdinit_rsp_buf #(.WORDS(4), .WORD_W(32)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .clr       (cmd_req),
    .vld       (rsp_valid),
    .word      (rsp_word),
    .last_word (last_w),
    .long_word (long_w),
    .scr       (scr_reg)
  );

  sdinit_csd_decode #(.SECT_W(SECT_W)) u_csd (
    .csd     (long_w),
    .ok      (csd_ok),
    .sectors (csd_sect)
  );

  assign bad        = cmd_err | cmd_tmo;
  assign scr_unused = ^{scr_reg[63:51], scr_reg[49:0]};

  // Request fields decoded from the current step.
  always_comb begin
    cmd_idx   = 6'd0;
    cmd_arg   = 32'd0;
    cmd_rtype = RSP_NONE;
    cmd_app   = 1'b0;
    cmd_data  = 1'b0;
    case (step)
      ST_GO_IDLE: begin
        cmd_idx = 6'd0;
      end
      ST_IF_COND: begin
        cmd_idx   = 6'd8;
        cmd_arg   = IF_COND_ARG;
        cmd_rtype = RSP_R7;
      end
      ST_OP_QUERY: begin
        cmd_idx   = 6'd41;
        cmd_rtype = RSP_R3;
        cmd_app   = 1'b1;
      end
      ST_OP_POLL: begin
        cmd_idx   = 6'd41;
        cmd_arg   = {1'b0, hcs, 30'd0} | vmask;
        cmd_rtype = RSP_R3;
        cmd_app   = 1'b1;
      end
      ST_GET_CID: begin
        cmd_idx   = 6'd2;
        cmd_rtype = RSP_R2;
      end
      ST_GET_RCA: begin
        cmd_idx   = 6'd3;
        cmd_rtype = RSP_R6;
      end
      ST_GET_CSD: begin
        cmd_idx   = 6'd9;
        cmd_arg   = {rca, 16'd0};
        cmd_rtype = RSP_R2;
      end
      ST_SELECT: begin
        cmd_idx   = 6'd7;
        cmd_arg   = {rca, 16'd0};
        cmd_rtype = RSP_R1B;
      end
      ST_GET_SCR: begin
        cmd_idx   = 6'd51;
        cmd_rtype = RSP_R1;
        cmd_app   = 1'b1;
        cmd_data  = 1'b1;
      end
      ST_BUS_WIDTH: begin
        cmd_idx   = 6'd6;
        cmd_arg   = WIDTH4_ARG;
        cmd_rtype = RSP_R1;
        cmd_app   = 1'b1;
      end
      default: cmd_idx = 6'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= ST_GO_IDLE;
      poll_cnt  <= '0;
      hcs       <= 1'b0;
      rca_retry <= 1'b0;
      vmask     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_code <= FC_NONE;
      cmd_req   <= 1'b0;
      phy_wide  <= 1'b0;
      ocr       <= '0;
      rca       <= '0;
      ccs       <= 1'b0;
      sect_cnt  <= '0;
      wide_ok   <= 1'b0;
    end else begin
      cmd_req <= 1'b0;
      if (start && !busy) begin
        step      <= ST_GO_IDLE;
        poll_cnt  <= '0;
        hcs       <= 1'b0;
        rca_retry <= 1'b0;
        vmask     <= '0;
        busy      <= 1'b1;
        done      <= 1'b0;
        fail      <= 1'b0;
        fail_code <= FC_NONE;
        cmd_req   <= 1'b1;
        phy_wide  <= 1'b0;
        ocr       <= '0;
        rca       <= '0;
        ccs       <= 1'b0;
        sect_cnt  <= '0;
        wide_ok   <= 1'b0;
      end else if (busy && cmd_done) begin
        case (step)
          ST_GO_IDLE: begin
            if (bad) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_GO_IDLE;
            end else begin
              step <= ST_IF_COND; cmd_req <= 1'b1;
            end
          end
          ST_IF_COND: begin
            if (cmd_tmo) begin
              hcs <= 1'b0; step <= ST_OP_QUERY; cmd_req <= 1'b1;
            end else if (cmd_err || (last_w[7:0] != ECHO_PAT)) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_IF_COND;
            end else begin
              hcs <= 1'b1; step <= ST_OP_QUERY; cmd_req <= 1'b1;
            end
          end
          ST_OP_QUERY: begin
            if (bad) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_OP_QUERY;
            end else if ((last_w & VOLT_WINDOW) == 32'd0) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_NO_VOLT;
            end else begin
              vmask    <= last_w & VOLT_WINDOW;
              poll_cnt <= '0;
              step     <= ST_OP_POLL;
              cmd_req  <= 1'b1;
            end
          end
          ST_OP_POLL: begin
            if (bad) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_OP_POLL;
            end else if (last_w[31]) begin
              ocr     <= last_w;
              ccs     <= last_w[30];
              step    <= ST_GET_CID;
              cmd_req <= 1'b1;
            end else if (poll_cnt == POLL_LAST) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_OP_TMO;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
              cmd_req  <= 1'b1;
            end
          end
          ST_GET_CID: begin
            if (bad) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_CID;
            end else begin
              rca_retry <= 1'b0; step <= ST_GET_RCA; cmd_req <= 1'b1;
            end
          end
          ST_GET_RCA: begin
            if (bad) begin
              if (!rca_retry) begin
                rca_retry <= 1'b1; cmd_req <= 1'b1;
              end else begin
                busy <= 1'b0; fail <= 1'b1; fail_code <= FC_RCA_ERR;
              end
            end else if (last_w[31:16] == 16'd0) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_RCA_ZERO;
            end else begin
              rca <= last_w[31:16]; step <= ST_GET_CSD; cmd_req <= 1'b1;
            end
          end
          ST_GET_CSD: begin
            if (bad) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_CSD;
            end else if (!csd_ok) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_CSD_FMT;
            end else begin
              sect_cnt <= csd_sect; step <= ST_SELECT; cmd_req <= 1'b1;
            end
          end
          ST_SELECT: begin
            if (bad) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_SELECT;
            end else begin
              step <= ST_GET_SCR; cmd_req <= 1'b1;
            end
          end
          ST_GET_SCR: begin
            if (bad) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_SCR;
            end else if (scr_reg[SCR_W4_BIT]) begin
              wide_ok <= 1'b1; step <= ST_BUS_WIDTH; cmd_req <= 1'b1;
            end else begin
              busy <= 1'b0; done <= 1'b1;
            end
          end
          ST_BUS_WIDTH: begin
            if (bad) begin
              busy <= 1'b0; fail <= 1'b1; fail_code <= FC_BUSW;
            end else begin
              phy_wide <= 1'b1; busy <= 1'b0; done <= 1'b1;
            end
          end
          default: begin
            busy <= 1'b0; fail <= 1'b1; fail_code <= FC_GO_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sdinit_seq_chk.sv
module sdinit_seq_chk #(
  parameter int SECT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [3:0]        fail_code,
  input logic              cmd_req,
  input logic              phy_wide,
  input logic              wide_ok,
  input logic [31:0]       ocr,
  input logic [15:0]       rca,
  input logic              ccs,
  input logic [SECT_W-1:0] sect_cnt
);

  p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done && !fail));

  p_ccs_from_ocr_r4: assert property (@(posedge clk) disable iff (rst)
    (done && ccs) |-> ocr[30]);

  p_ready_ocr_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> ocr[31]);

  p_rca_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (rca != 16'd0));

  p_phy_needs_cap_r9: assert property (@(posedge clk) disable iff (rst)
    phy_wide |-> wide_ok);

  p_code_set_r10: assert property (@(posedge clk) disable iff (rst)
    fail |-> (fail_code != 4'd0));

  p_verdict_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  p_done_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(rca) && $stable(sect_cnt) && $stable(ocr)));

  p_fail_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> (fail && $stable(fail_code)));

  p_req_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_req |=> !cmd_req);

  p_req_in_run_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> busy);

endmodule

bind sdinit_seq sdinit_seq_chk #(.SECT_W(SECT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .fail_code (fail_code),
  .cmd_req   (cmd_req),
  .phy_wide  (phy_wide),
  .wide_ok   (wide_ok),
  .ocr       (ocr),
  .rca       (rca),
  .ccs       (ccs),
  .sect_cnt  (sect_cnt)
);

// File: tb/sdinit_seq_bench.sv
module sdinit_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int POLL_LIMIT = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic busy, done, fail, cmd_req, cmd_app, cmd_data, phy_wide, ccs, wide_ok;
  logic [3:0]  fail_code;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg, ocr;
  logic [2:0]  cmd_rtype;
  logic [15:0] rca;
  logic [31:0] sect_cnt;
  logic        rsp_valid = 1'b0, cmd_done = 1'b0, cmd_err = 1'b0, cmd_tmo = 1'b0;
  logic [31:0] rsp_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdinit_seq #(.MAX_OP_POLLS(POLL_LIMIT), .SECT_W(32)) u_sdinit_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fail(fail),
    .fail_code(fail_code), .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .cmd_rtype(cmd_rtype), .cmd_app(cmd_app), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .cmd_done(cmd_done),
    .cmd_err(cmd_err), .cmd_tmo(cmd_tmo), .phy_wide(phy_wide), .ocr(ocr),
    .rca(rca), .ccs(ccs), .sect_cnt(sect_cnt), .wide_ok(wide_ok)
  );

  int n_chk = 0, n_fail = 0;

  // card model configuration
  int          c_ifc;        // 0 echo ok, 1 no response, 2 bad echo
  logic [31:0] c_ocr;
  int          c_ready;
  logic        c_ccs;
  int          c_rca_fails;
  logic [15:0] c_rca;
  logic [127:0] c_csd;
  logic [63:0] c_scr;
  int          c_err_idx;
  logic        c_err_poll;

  int n_cmds, n_polls, n_rca;
  bit seen_query;

  task automatic chkv(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] csd_hc(input logic [21:0] sz);
    logic [127:0] c = '0;
    c[127:126] = 2'd1;
    c[69:48]   = sz;
    c[7:0]     = 8'h01;
    return c;
  endfunction

  function automatic logic [127:0] csd_sc(input logic [11:0] sz, input logic [2:0] m, input logic [3:0] bl);
    logic [127:0] c = '0;
    c[127:126] = 2'd0;
    c[73:62]   = sz;
    c[49:47]   = m;
    c[83:80]   = bl;
    return c;
  endfunction

  function automatic logic [63:0] mk_scr(input bit w4);
    logic [63:0] s = '0;
    s[63:56] = 8'h02;
    s[51:48] = w4 ? 4'b0101 : 4'b0001;
    s[47:40] = w4 ? 8'h00 : 8'h04;   // decoy at bit 42
    s[31:0]  = 32'h1234_5678;
    return s;
  endfunction

  function automatic logic [31:0] scr_word(input logic [63:0] s, input int j);
    logic [31:0] w;
    for (int b = 0; b < 4; b++) w[b*8 +: 8] = s[(7-(4*j+b))*8 +: 8];
    return w;
  endfunction

  task automatic defaults();
    c_ifc = 0; c_ocr = 32'h00FF_8000; c_ready = 1; c_ccs = 1'b1;
    c_rca_fails = 0; c_rca = 16'hB368; c_csd = csd_hc(22'd1000);
    c_scr = mk_scr(1'b1); c_err_idx = -1; c_err_poll = 1'b0;
  endtask

  // command engine and card model
  task automatic serve();
    logic [5:0]  idx  = cmd_idx;
    logic [31:0] arg  = cmd_arg;
    logic [2:0]  rt   = cmd_rtype;
    logic        app  = cmd_app;
    logic        dat  = cmd_data;
    logic [31:0] w [4];
    int nw = 0;
    bit e = 0, t = 0;
    logic [31:0] exp_poll;
    n_cmds++;
    case (idx)
      6'd0: begin
        chkv("R1 CMD0 arg", arg, 0); chkv("R1 CMD0 kind", rt, 0); chkv("R1 CMD0 app", app, 0);
      end
      6'd8: begin
        chkv("R2 CMD8 arg", arg, 32'h1A5); chkv("R2 CMD8 kind", rt, 6);
        if (c_ifc == 1) t = 1;
        else begin w[0] = (c_ifc == 0) ? 32'h0000_01A5 : 32'h0000_015A; nw = 1; end
      end
      6'd41: begin
        chkv("R3 ACMD41 app", app, 1); chkv("R3 ACMD41 kind", rt, 4);
        if (!seen_query) begin
          seen_query = 1;
          chkv("R3 query arg", arg, 0);
          w[0] = c_ocr; nw = 1;
          if (c_err_idx == 41) e = 1;
        end else begin
          n_polls++;
          exp_poll = ((c_ifc == 0) ? 32'h4000_0000 : 32'h0) | (c_ocr & 32'h00FF_8000);
          chkv("R4 poll arg", arg, exp_poll);
          if (c_err_poll) e = 1;
          w[0] = (n_polls >= c_ready) ? (c_ocr | 32'h8000_0000 | {1'b0, c_ccs, 30'd0}) : c_ocr;
          nw = 1;
        end
      end
      6'd2: begin
        chkv("R6 CMD2 kind", rt, 3);
        w[0] = 32'h0353_4453; w[1] = 32'h4331_3647; w[2] = 32'h8012_3456; w[3] = 32'h7801_4301; nw = 4;
      end
      6'd3: begin
        chkv("R6 CMD3 kind", rt, 5);
        n_rca++;
        if (n_rca <= c_rca_fails) e = 1;
        else begin w[0] = {c_rca, 16'h0520}; nw = 1; end
      end
      6'd9: begin
        chkv("R7 CMD9 arg", arg, {c_rca, 16'h0}); chkv("R7 CMD9 kind", rt, 3);
        for (int k = 0; k < 4; k++) w[k] = c_csd[(3-k)*32 +: 32];
        nw = 4;
      end
      6'd7: begin
        chkv("R7 CMD7 arg", arg, {c_rca, 16'h0}); chkv("R7 CMD7 kind", rt, 2);
        w[0] = 32'h0000_0700; nw = 1;
      end
      6'd51: begin
        chkv("R9 ACMD51 app", app, 1); chkv("R9 ACMD51 data", dat, 1);
        w[0] = scr_word(c_scr, 0); w[1] = scr_word(c_scr, 1); nw = 2;
      end
      6'd6: begin
        chkv("R9 ACMD6 arg", arg, 2); chkv("R9 ACMD6 app", app, 1);
        w[0] = 32'h0000_0900; nw = 1;
      end
      default: chkv("R12 unexpected index", idx, 0);
    endcase
    if (int'(idx) == c_err_idx && idx != 6'd41) e = 1;
    if (e || t) nw = 0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < nw; k++) begin
      rsp_valid = 1'b1; rsp_word = w[k];
      @(negedge clk);
    end
    rsp_valid = 1'b0;
    cmd_done = 1'b1; cmd_err = e; cmd_tmo = t;
    @(negedge clk);
    cmd_done = 1'b0; cmd_err = 1'b0; cmd_tmo = 1'b0;
    chkv("R12 request or verdict one cycle after done", cmd_req | done | fail, 1);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (cmd_req) serve();
    end
  end

  task automatic launch();
    n_cmds = 0; n_polls = 0; n_rca = 0; seen_query = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_wait();
    while (!(done || fail)) @(negedge clk);
  endtask

  task automatic run();
    launch();
    finish_wait();
  endtask

  task automatic expect_fail(input string tag, input int code);
    chkv({tag, " fail"}, fail, 1);
    chkv({tag, " done"}, done, 0);
    chkv({tag, " code"}, fail_code, code);
  endtask

  task automatic expect_ok(input logic [31:0] sect_exp, input bit w4);
    int exp_cmds = 6 + c_ready + 1 + c_rca_fails + (w4 ? 1 : 0) + 1;
    chkv("R10 done", done, 1);
    chkv("R10 code zero", fail_code, 0);
    chkv("R4 ocr", ocr, c_ocr | 32'h8000_0000 | {1'b0, c_ccs, 30'd0});
    chkv("R4 ccs", ccs, c_ccs);
    chkv("R4 poll count", n_polls, c_ready);
    chkv("R6 rca", rca, c_rca);
    chkv("R8 sector count", sect_cnt, sect_exp);
    chkv("R9 wide_ok", wide_ok, w4);
    chkv("R9 phy_wide", phy_wide, w4);
    chkv("R12 command count", n_cmds, exp_cmds);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] sexp;
    logic [15:0] hold_rca;
    defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chkv("R1 reset busy", busy, 0); chkv("R1 reset done", done, 0);
    chkv("R1 reset fail", fail, 0); chkv("R1 reset code", fail_code, 0);
    chkv("R1 reset req", cmd_req, 0); chkv("R1 reset phy", phy_wide, 0);
    chkv("R1 reset rca", rca, 0); chkv("R1 reset sect", sect_cnt, 0);

    // success sweep
    for (int m = 0; m < 2; m++)
      for (int cc = 0; cc < 2; cc++)
        for (int w4 = 0; w4 < 2; w4++)
          for (int rd = 0; rd < 2; rd++)
            for (int v = 0; v < 2; v++) begin
              defaults();
              c_ifc   = m;
              c_ccs   = cc[0];
              c_ready = rd ? POLL_LIMIT : 1;
              c_ocr   = (m + v == 1) ? 32'h0030_0000 : 32'h00FF_8000;
              c_scr   = mk_scr(w4[0]);
              c_rca   = 16'h1000 + 16'(m*16 + cc*8 + w4*4 + rd*2 + v);
              if (v == 0) begin
                c_csd = csd_hc(22'(7000 + 13*(cc + 2*rd)));
                sexp  = (32'(7000 + 13*(cc + 2*rd)) + 1) * 1024;
              end else begin
                c_csd = csd_sc(12'(2000 + 3*w4), 3'(4 + rd), 4'(9 + cc));
                sexp  = ((32'(2000 + 3*w4) + 1) * (32'd1 << (4 + rd + 2)) * (32'd1 << (9 + cc))) / 512;
              end
              run();
              expect_ok(sexp, w4[0]);
            end

    // R2: wrong echo
    defaults(); c_ifc = 2; run();
    expect_fail("R2 bad echo", 2); chkv("R2 commands before stop", n_cmds, 2);

    // R3: no voltage window
    defaults(); c_ocr = 32'h0000_0080; run();
    expect_fail("R3 no voltage", 4); chkv("R3 commands before stop", n_cmds, 3);

    // R5: never ready
    defaults(); c_ready = POLL_LIMIT + 1; run();
    expect_fail("R5 poll limit", 6); chkv("R5 polls issued", n_polls, POLL_LIMIT);

    // R6: one CMD3 failure recovers, two stop
    defaults(); c_rca_fails = 1; run();
    expect_ok((32'd1000 + 1) * 1024, 1'b1); chkv("R6 CMD3 tries", n_rca, 2);
    defaults(); c_rca_fails = 2; run();
    expect_fail("R6 CMD3 twice", 8); chkv("R6 CMD3 tries on stop", n_rca, 2);
    defaults(); c_rca = 16'h0000; run();
    expect_fail("R6 zero address", 9);

    // R8: unsupported layouts
    defaults(); c_csd = csd_hc(22'd5); c_csd[127:126] = 2'd2; run();
    expect_fail("R8 layout 2", 11);
    defaults(); c_csd = csd_sc(12'd100, 3'd2, 4'd8); run();
    expect_fail("R8 short block length", 11);

    // R10: error injected at each step
    defaults(); c_err_idx = 0;  run(); expect_fail("R10 CMD0 error", 1);
    defaults(); c_err_idx = 8;  run(); expect_fail("R2 CMD8 error", 2);
    defaults(); c_err_idx = 41; run(); expect_fail("R3 query error", 3);
    defaults(); c_err_poll = 1; run(); expect_fail("R4 poll error", 5);
    defaults(); c_err_idx = 2;  run(); expect_fail("R10 CMD2 error", 7);
    defaults(); c_err_idx = 9;  run(); expect_fail("R7 CMD9 error", 10);
    defaults(); c_err_idx = 7;  run(); expect_fail("R7 CMD7 error", 12);
    defaults(); c_err_idx = 51; run(); expect_fail("R10 ACMD51 error", 13);
    defaults(); c_err_idx = 6;  run(); expect_fail("R10 ACMD6 error", 14);
    chkv("R9 phy stays narrow after ACMD6 error", phy_wide, 0);

    // R11: start while busy ignored, hold, restart clears
    defaults();
    launch();
    repeat (12) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    finish_wait();
    expect_ok((32'd1000 + 1) * 1024, 1'b1);
    hold_rca = rca;
    repeat (20) @(negedge clk);
    chkv("R11 done holds", done, 1);
    chkv("R11 rca holds", rca, hold_rca);
    chkv("R11 phy holds", phy_wide, 1);
    launch();
    chkv("R11 restart clears done", done, 0);
    chkv("R11 restart clears rca", rca, 0);
    chkv("R11 restart clears phy", phy_wide, 0);
    chkv("R1 restart busy", busy, 1);
    finish_wait();
    chkv("R11 second run done", done, 1);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule